// File: doc/BRIEF.md
# Dual-Modulus Clock Prescaler

The block divides an input clock by one of two adjacent ratios, N or N+1. Its main use is as the front divider of a pulse-swallow frequency synthesiser. Two active-high control inputs are merged by OR. If either input is high, the current output period uses the smaller ratio N. Only when both inputs are low does the period use N+1. A build-time parameter picks the ratio pair, either 8/9 or 10/11.

Everything in the block runs on rising edges of the input clock. A four-bit state register counts through the states of one output period. At the edge that ends a period, the merged control level is sampled, and that value fixes the length of the period that starts at the same edge. A control change that arrives after this edge first affects the following period. The divided output comes straight from a flip-flop. It is driven out in true and complementary form, and a parameter can add a single-ended copy. A synchronous reset forces the output low and starts a period at the larger ratio. This matches the case of both control inputs left low.

Top module: `dmp_prescaler`

## Requirements
- R1: At a rising edge with `rst` high, `div_q` goes to 0 and `div_qn` goes to 1. The period that starts at that edge lasts LOW_RATIO+1 input clocks, whatever the control inputs are doing.
- R2: When both `mod_ctl_a` and `mod_ctl_b` are 0 at the edge where a period starts, that period lasts LOW_RATIO+1 input clocks.
- R3: When either `mod_ctl_a` or `mod_ctl_b` is 1 at the edge where a period starts, that period lasts LOW_RATIO input clocks.
- R4: A period starts at the rising clock edge on which `div_q` falls (or at the reset edge). Control levels at every other edge have no effect on the length of that period.
- R5: `div_qn` is always the inverse of `div_q`. With SE_EN=1, `div_se` equals `div_q`. With SE_EN=0, `div_se` is held at 0.
- R6: In every period `div_q` is high for LOW_RATIO/2 input clocks and low for the rest. The extra clock of an N+1 period is added to the low phase, so high and low times differ by at most one clock.
- R7: LOW_RATIO=10 gives the 10/11 pair and LOW_RATIO=8 gives the 8/9 pair. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; counting and control sampling use its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mod_ctl_a | input | 1 | Modulus control, high selects the smaller ratio |
| mod_ctl_b | input | 1 | Second modulus control, ORed with the first |
| div_q | output | 1 | Divided output, true form |
| div_qn | output | 1 | Divided output, complementary form |
| div_se | output | 1 | Optional single-ended copy of the divided output (0 when disabled) |

## Verification
The bound checker measures every period on every cycle. At each falling edge of the output it compares the period length with the ratio implied by the merged control level at the previous fall. It also checks the length of the high phase, the complement relation, the single-ended copy and the output state after reset. Some behaviour shows up only in the bench scenarios: that a control change landing one clock before or after the sampling edge moves the ratio change by a whole period, that both ratio pairs behave the same way, and that a reset in the middle of a period starts a clean N+1 period. The bench scoreboard queues one expected length per period from the control value it saw, and pops and compares it at the next fall.

// File: rtl/dmp_pkg.sv
package dmp_pkg;

   // Modulus chosen for one output period
   typedef enum logic {
      MOD_HIGH = 1'b0,
      MOD_LOW  = 1'b1
   } mod_sel_e;

   // Number of input clocks in one output period
   function automatic int unsigned period_cycles(input int unsigned low_ratio,
                                                 input mod_sel_e sel);
      return (sel == MOD_LOW) ? low_ratio : low_ratio + 1;
   endfunction

endpackage

// File: rtl/dmp_ctl_merge.sv
module dmp_ctl_merge #(
   parameter int unsigned NUM_CTL = 2
) (
   input  logic [NUM_CTL-1:0] ctl,
   output logic               any_high
);

   logic [NUM_CTL:0] chain;

   assign chain[0] = 1'b0;

   generate
      for (genvar i = 0; i < NUM_CTL; i++) begin : g_or
         assign chain[i+1] = chain[i] | ctl[i];
      end
   endgenerate

   assign any_high = chain[NUM_CTL];

endmodule

// File: rtl/dmp_seq.sv
module dmp_seq
   import dmp_pkg::*;
#(
   parameter int unsigned LOW_RATIO = 10,
   parameter int unsigned CW        = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          req_low,
   output logic [CW-1:0] cnt_nxt,
   output mod_sel_e      sel_nxt
);

   localparam logic [CW-1:0] LAST_LOW  = CW'(period_cycles(LOW_RATIO, MOD_LOW) - 1);
   localparam logic [CW-1:0] LAST_HIGH = CW'(period_cycles(LOW_RATIO, MOD_HIGH) - 1);
   localparam logic [CW-1:0] ONE       = CW'(1);

   logic [CW-1:0] cnt_q;
   mod_sel_e      sel_q;
   logic          wrap;

   always_comb begin
      wrap = (sel_q == MOD_LOW) ? (cnt_q == LAST_LOW) : (cnt_q == LAST_HIGH);
      if (wrap) begin
         cnt_nxt = '0;
         sel_nxt = req_low ? MOD_LOW : MOD_HIGH;
      end else begin
         cnt_nxt = cnt_q + ONE;
         sel_nxt = sel_q;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         sel_q <= MOD_HIGH;
      end else begin
         cnt_q <= cnt_nxt;
         sel_q <= sel_nxt;
      end
   end

endmodule

// File: rtl/dmp_out_stage.sv
module dmp_out_stage
   import dmp_pkg::*;
#(
   parameter int unsigned LOW_RATIO = 10,
   parameter int unsigned CW        = 4,
   parameter bit          SE_EN     = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [CW-1:0] cnt_nxt,
   input  mod_sel_e      sel_nxt,
   output logic          q,
   output logic          qn,
   output logic          se
);

   localparam int unsigned HALF      = LOW_RATIO / 2;
   localparam logic [CW-1:0] RISE_LOW  = CW'(period_cycles(LOW_RATIO, MOD_LOW) - HALF);
   localparam logic [CW-1:0] RISE_HIGH = CW'(period_cycles(LOW_RATIO, MOD_HIGH) - HALF);

   logic [CW-1:0] rise_at;
   logic          out_q;

   always_comb begin
      rise_at = (sel_nxt == MOD_LOW) ? RISE_LOW : RISE_HIGH;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_q <= 1'b0;
      end else begin
         out_q <= (cnt_nxt >= rise_at);
      end
   end

   assign q  = out_q;
   assign qn = ~out_q;

   generate
      if (SE_EN) begin : g_se_on
         assign se = out_q;
      end else begin : g_se_off
         assign se = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/dmp_prescaler.sv
module dmp_prescaler
   import dmp_pkg::*;
#(
   parameter int unsigned LOW_RATIO = 10,
   parameter bit          SE_EN     = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic mod_ctl_a,
   input  logic mod_ctl_b,
   output logic div_q,
   output logic div_qn,
   output logic div_se
);

   localparam int unsigned NUM_CTL = 2;
   localparam int unsigned CW      = $clog2(LOW_RATIO + 1);

   generate
      if (!(LOW_RATIO == 8 || LOW_RATIO == 10)) begin : g_bad_ratio
         $error("dmp_prescaler: LOW_RATIO must be 8 or 10");
      end
      if (CW != 4) begin : g_bad_width
         $error("dmp_prescaler: state register must be four bits wide");
      end
   endgenerate

   logic          req_low;
   logic [CW-1:0] cnt_nxt;
   mod_sel_e      sel_nxt;

   dmp_ctl_merge #(
      .NUM_CTL (NUM_CTL)
   ) merge_i (
      .ctl      ({mod_ctl_b, mod_ctl_a}),
      .any_high (req_low)
   );

   dmp_seq #(
      .LOW_RATIO (LOW_RATIO),
      .CW        (CW)
   ) seq_i (
      .clk     (clk),
      .rst     (rst),
      .req_low (req_low),
      .cnt_nxt (cnt_nxt),
      .sel_nxt (sel_nxt)
   );

   dmp_out_stage #(
      .LOW_RATIO (LOW_RATIO),
      .CW        (CW),
      .SE_EN     (SE_EN)
   ) out_i (
      .clk     (clk),
      .rst     (rst),
      .cnt_nxt (cnt_nxt),
      .sel_nxt (sel_nxt),
      .q       (div_q),
      .qn      (div_qn),
      .se      (div_se)
   );

endmodule

// File: rtl/dmp_prescaler_chk.sv
module dmp_prescaler_chk #(
   parameter int unsigned LOW_RATIO = 10,
   parameter bit          SE_EN     = 1'b1
) (
   input logic clk,
   input logic rst,
   input logic mod_ctl_a,
   input logic mod_ctl_b,
   input logic div_q,
   input logic div_qn,
   input logic div_se
);

   localparam logic [4:0] LEN_LOW  = 5'(LOW_RATIO);
   localparam logic [4:0] LEN_HIGH = 5'(LOW_RATIO + 1);
   localparam logic [4:0] LEN_HI_PH = 5'(LOW_RATIO / 2);

   logic       ctl_any;
   logic       prev_ctl_q;
   logic       prev_q_q;
   logic       exp_low_q;
   logic       fell;
   logic [4:0] run_q;
   logic [4:0] hi_q;

   assign ctl_any = mod_ctl_a | mod_ctl_b;
   assign fell    = prev_q_q & ~div_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_ctl_q <= 1'b0;
         prev_q_q   <= 1'b0;
         exp_low_q  <= 1'b0;
         run_q      <= '0;
         hi_q       <= '0;
      end else begin
         prev_ctl_q <= ctl_any;
         prev_q_q   <= div_q;
         if (fell) begin
            run_q     <= 5'd1;
            exp_low_q <= prev_ctl_q;
         end else begin
            run_q <= run_q + 5'd1;
         end
         hi_q <= div_q ? hi_q + 5'd1 : 5'd0;
      end
   end

   // R2 R3 R4 R7
   period_len_chk: assert property (@(posedge clk) disable iff (rst)
      fell |-> (run_q == (exp_low_q ? LEN_LOW : LEN_HIGH)));

   // R6
   high_len_chk: assert property (@(posedge clk) disable iff (rst)
      fell |-> (hi_q == LEN_HI_PH));

   // R5
   compl_chk: assert property (@(posedge clk) disable iff (rst)
      div_qn == ~div_q);

   // R5
   se_copy_chk: assert property (@(posedge clk) disable iff (rst)
      div_se == (SE_EN ? div_q : 1'b0));

   // R1
   reset_out_chk: assert property (@(posedge clk)
      rst |=> (!div_q && div_qn));

endmodule

bind dmp_prescaler dmp_prescaler_chk #(
   .LOW_RATIO (LOW_RATIO),
   .SE_EN     (SE_EN)
) chk_i (
   .clk       (clk),
   .rst       (rst),
   .mod_ctl_a (mod_ctl_a),
   .mod_ctl_b (mod_ctl_b),
   .div_q     (div_q),
   .div_qn    (div_qn),
   .div_se    (div_se)
);

// File: tb/dmp_prescaler_tb_top.sv
module dmp_prescaler_tb_top;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ctl_a = 1'b0;
   logic ctl_b = 1'b0;

   logic q10, qn10, se10;
   logic q8, qn8, se8;

   logic rst_seen = 1'b1;
   logic ctl_seen = 1'b0;

   int m_pass = 0;
   int m_fail = 0;
   int wd_fail = 0;

   always #10 clk = ~clk;

   // R7: one instance per ratio pair; the 8/9 instance has its single-ended copy disabled
   dmp_prescaler #(.LOW_RATIO(10), .SE_EN(1'b1)) dut_i (
      .clk(clk), .rst(rst), .mod_ctl_a(ctl_a), .mod_ctl_b(ctl_b),
      .div_q(q10), .div_qn(qn10), .div_se(se10));

   dmp_prescaler #(.LOW_RATIO(8), .SE_EN(1'b0)) dut8_i (
      .clk(clk), .rst(rst), .mod_ctl_a(ctl_a), .mod_ctl_b(ctl_b),
      .div_q(q8), .div_qn(qn8), .div_se(se8));

   // Values seen by the design at each rising edge
   always @(posedge clk) begin
      rst_seen <= rst;
      ctl_seen <= ctl_a | ctl_b;
   end

   // Scoreboard monitors, one per instance
   for (genvar g = 0; g < 2; g++) begin : mon
      localparam int LOWR = (g == 0) ? 10 : 8;
      localparam bit HAS_SE = (g == 0);
      int exp_q[$];
      int npass = 0;
      int nfail = 0;
      int run = 0;
      int hi = 0;
      logic prev = 1'b0;

      always @(negedge clk) begin
         logic o, on, os;
         o  = (g == 0) ? q10  : q8;
         on = (g == 0) ? qn10 : qn8;
         os = (g == 0) ? se10 : se8;
         if (rst_seen) begin
            // R1: period started by reset uses the larger ratio
            exp_q.delete();
            exp_q.push_back(LOWR + 1);
            run  = 0;
            hi   = 0;
            prev = 1'b0;
         end else begin
            run++;
            if (o) hi++;
            if (prev && !o) begin
               int exp_len;
               exp_len = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
               // R2 R3 R4 R7: length set by control seen at the period's first edge
               if (run == exp_len) npass++;
               else begin
                  nfail++;
                  $display("FAIL R2/R3/R4/R7 ratio%0d period: actual %0d expected %0d", LOWR, run, exp_len);
               end
               // R6: high phase length
               if (hi == LOWR / 2) npass++;
               else begin
                  nfail++;
                  $display("FAIL R6 ratio%0d high time: actual %0d expected %0d", LOWR, hi, LOWR / 2);
               end
               // R5: complement and single-ended copy
               if (on == ~o && os == (HAS_SE ? o : 1'b0)) npass++;
               else begin
                  nfail++;
                  $display("FAIL R5 ratio%0d outputs: actual qn=%0b se=%0b expected qn=%0b se=%0b",
                           LOWR, on, os, ~o, (HAS_SE ? o : 1'b0));
               end
               exp_q.push_back(ctl_seen ? LOWR : LOWR + 1);
               run = 0;
               hi  = 0;
            end
            prev = o;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      if (ok) m_pass++;
      else begin
         m_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic drive(input logic a, input logic b, input int n);
      @(negedge clk);
      ctl_a = a;
      ctl_b = b;
      repeat (n - 1) @(negedge clk);
   endtask

   task automatic summary();
      int p, f;
      p = m_pass + mon[0].npass + mon[1].npass;
      f = m_fail + wd_fail + mon[0].nfail + mon[1].nfail;
      $display("%0d/%0d checks passed", p, p + f);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(q10 == 1'b0 && qn10 == 1'b1, "R1 reset ratio10 q/qn", {q10, qn10}, 2'b01);
      chk(q8 == 1'b0 && qn8 == 1'b1, "R1 reset ratio8 q/qn", {q8, qn8}, 2'b01);
      chk(se8 == 1'b0, "R5 se disabled", se8, 0);
      // R1: controls high during and after reset must not shorten the first period
      ctl_a = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      repeat (4) @(negedge clk);
      ctl_a = 1'b0;

      drive(1'b0, 1'b0, 60);   // R2: both low
      drive(1'b1, 1'b0, 60);   // R3: first input high
      drive(1'b0, 1'b1, 60);   // R3: second input high
      drive(1'b1, 1'b1, 60);   // R3: both high
      drive(1'b0, 1'b0, 30);

      // R4: short pulses at arbitrary phases; only the value at a period start counts
      for (int i = 0; i < 300; i++) begin
         drive(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), int'($urandom_range(1, 7)));
      end
      for (int i = 0; i < 40; i++) begin
         drive(1'b1, 1'b0, 1);
         drive(1'b0, 1'b0, 9 + (i % 4));
      end

      // R1: reset in the middle of a period
      drive(1'b0, 1'b1, 23);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk(q10 == 1'b0 && qn10 == 1'b1, "R1 mid-run reset ratio10", {q10, qn10}, 2'b01);
      chk(q8 == 1'b0 && qn8 == 1'b1, "R1 mid-run reset ratio8", {q8, qn8}, 2'b01);
      rst = 1'b0;
      drive(1'b0, 1'b0, 50);
      drive(1'b1, 1'b1, 50);
      repeat (30) @(negedge clk);

      // R2 R7: scoreboard must have measured a meaningful number of periods
      chk(mon[0].npass + mon[0].nfail > 150, "R2 ratio10 periods measured",
          mon[0].npass + mon[0].nfail, 151);
      chk(mon[1].npass + mon[1].nfail > 150, "R7 ratio8 periods measured",
          mon[1].npass + mon[1].nfail, 151);
      summary();
      $finish;
   end

   initial begin
      #(20 * 200000);
      wd_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

endmodule